// File: doc/BRIEF.md
# Shared-Adder Add/Subtract Unit

A purely combinational two's-complement arithmetic unit that forms either the sum or the difference of two operands on a single chain of full-adder slices. The operation is chosen by one mode bit. When mode is 0 the unit adds. When mode is 1 it subtracts.

Subtraction reuses the same chain. Each bit of the second operand is passed through an XOR gate with the mode bit, and the mode bit also drives the carry-in of the lowest slice. The chain therefore computes A + ~B + 1 with no second adder and no separate negation stage.

The unit reports three outputs:
- the truncated result;
- the raw carry out of the top slice;
- a signed-overflow flag, taken from the carries around the sign slice.

The operand width is a parameter with a default of 4 and a minimum of 2. Results appear in the same cycle the inputs are applied, so the unit drops directly into a datapath between registers.

Top module: `addsub_unit`

## Requirements
- R1: With `sub_i` = 0, `result_o` equals (a_i + b_i) modulo 2^WIDTH.
- R2: With `sub_i` = 1, `result_o` equals (a_i - b_i) modulo 2^WIDTH. For example, a_i = 4'b0101 and b_i = 4'b0110 give 4'b1111.
- R3: With `sub_i` = 0, `overflow_o` is 1 exactly when both operands have the same sign bit (bit WIDTH-1) and the result's sign bit differs from it.
- R4: With `sub_i` = 1, `overflow_o` is 1 exactly when the operands' sign bits differ and the result's sign bit differs from the sign bit of a_i.
- R5: With `sub_i` = 0, `carry_o` equals bit WIDTH of the unsigned (WIDTH+1)-bit sum of a_i and b_i.
- R6: With `sub_i` = 1, `carry_o` is 1 exactly when a_i >= b_i as unsigned numbers, meaning no borrow.
- R7: `overflow_o` is never 1 in two cases:
  - adding operands whose sign bits differ;
  - subtracting operands whose sign bits are equal.
- R8: With `sub_i` = 1 and b_i = 0:
  - `result_o` equals a_i;
  - `carry_o` is 1;
  - `overflow_o` is 0.
- R9: All outputs depend only on the current inputs and are valid in the same cycle the inputs are applied, with no state carried between cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend in subtract mode) |
| b_i | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| result_o | output | WIDTH | Truncated sum or difference |
| carry_o | output | 1 | Carry out of the top slice; in subtract mode 1 means no borrow |
| overflow_o | output | 1 | Signed two's-complement overflow |

## Verification
The unsigned carry and the signed overflow come from the same chain and can both be raised by a single operand pair. For example, -8 + -8 at width 4 wraps to 0 with carry 1 and overflow 1. In subtract mode, 0 - 8 sets overflow while also signalling a borrow.

Every operand pair in both modes is applied, so every combination of carry and overflow is reached. Each output is judged on its own against an integer reference:
- overflow is taken from whether the signed result leaves the representable range;
- carry is taken from an unsigned comparison.

A wrong carry into the sign slice therefore shows up separately in each flag.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  localparam int unsigned MIN_WIDTH = 2;
endpackage

// File: rtl/addsub_fa.sv
`timescale 1ns/1ps
module addsub_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o
);
  assign sum_o  = x_i ^ y_i ^ cin_i;
  assign cout_o = (x_i & y_i) | (x_i & cin_i) | (y_i & cin_i);
endmodule

// File: rtl/addsub_bcond.sv
`timescale 1ns/1ps
// Conditional inversion of the second operand: one XOR per bit.
module addsub_bcond #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] b_o
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_xor
    assign b_o[k] = b_i[k] ^ inv_i;
  end
endmodule

// File: rtl/addsub_chain.sv
`timescale 1ns/1ps
module addsub_chain #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             c_msb_in_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] c;

  assign c[0] = cin_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_slice
    addsub_fa u_fa (
      .x_i   (x_i[k]),
      .y_i   (y_i[k]),
      .cin_i (c[k]),
      .sum_o (sum_o[k]),
      .cout_o(c[k+1])
    );
  end

  assign cout_o     = c[WIDTH];
  assign c_msb_in_o = c[MSB];
endmodule

// File: rtl/addsub_unit.sv
`timescale 1ns/1ps
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             overflow_o
);
  if (WIDTH < MIN_WIDTH) begin : g_bad_width
    $error("addsub_unit: WIDTH below minimum");
  end

  op_e             op;
  logic            mode;
  logic [WIDTH-1:0] b_cond;
  logic            c_top;
  logic            c_msb_in;

  assign op   = op_e'(sub_i);
  assign mode = (op == OP_SUB);

  addsub_bcond #(.WIDTH(WIDTH)) u_bcond (
    .b_i  (b_i),
    .inv_i(mode),
    .b_o  (b_cond)
  );

  // mode doubles as the +1 of the two's complement
  addsub_chain #(.WIDTH(WIDTH)) u_chain (
    .x_i       (a_i),
    .y_i       (b_cond),
    .cin_i     (mode),
    .sum_o     (result_o),
    .cout_o    (c_top),
    .c_msb_in_o(c_msb_in)
  );

  assign carry_o    = c_top;
  assign overflow_o = c_top ^ c_msb_in;
endmodule

// File: rtl/addsub_checker.sv
`timescale 1ns/1ps
module addsub_checker #(
  parameter int unsigned WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             overflow_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] wide_add;
  logic [WIDTH:0] wide_sub;
  logic           sa, sb, sr;

  assign wide_add = {1'b0, a_i} + {1'b0, b_i};
  assign wide_sub = {1'b0, a_i} - {1'b0, b_i};
  assign sa = a_i[MSB];
  assign sb = b_i[MSB];
  assign sr = result_o[MSB];

  always_comb begin
    if (!sub_i) begin
      assert_add_sum_R1: assert (result_o == wide_add[WIDTH-1:0]);
      assert_add_ovf_R3: assert (overflow_o == ((sa == sb) && (sr != sa)));
      assert_add_carry_R5: assert (carry_o == wide_add[WIDTH]);
      assert_no_overflow_R7: assert (!(sa != sb) || !overflow_o);
    end else begin
      assert_sub_diff_R2: assert (result_o == wide_sub[WIDTH-1:0]);
      assert_sub_ovf_R4: assert (overflow_o == ((sa != sb) && (sr != sa)));
      assert_sub_carry_R6: assert (carry_o == (a_i >= b_i));
      assert_sub_no_overflow_R7: assert (!(sa == sb) || !overflow_o);
      if (b_i == '0) begin
        assert_sub_zero_R8: assert (result_o == a_i && carry_o && !overflow_o);
      end
    end
  end
endmodule

bind addsub_unit addsub_checker #(.WIDTH(WIDTH)) u_addsub_checker (
  .a_i       (a_i),
  .b_i       (b_i),
  .sub_i     (sub_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .overflow_o(overflow_o)
);

// File: tb/addsub_unit_tb_top.sv
`timescale 1ns/1ps
module addsub_unit_tb_top;
  localparam int W    = 4;
  localparam int SPAN = 1 << W;
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int SMIN = -(1 << (W - 1));

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic         sub;
  logic [W-1:0] res;
  logic         cy, ov;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addsub_unit #(.WIDTH(W)) dut_i (
    .a_i       (a),
    .b_i       (b),
    .sub_i     (sub),
    .result_o  (res),
    .carry_o   (cy),
    .overflow_o(ov)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: a=%0d b=%0d sub=%0d actual=%0d expected=%0d",
               req, a, b, sub, act, exp);
    end
  endtask

  function automatic int to_signed(input int v);
    return (v > SMAX) ? v - SPAN : v;
  endfunction

  task automatic apply_and_check(input int av, input int bv, input bit sv);
    int sa, sb, ssum, usum, exp_res, exp_cy, exp_ov;
    @(posedge clk);
    a   = W'(av);
    b   = W'(bv);
    sub = sv;
    @(negedge clk);
    sa = to_signed(av);
    sb = to_signed(bv);
    if (!sv) begin
      usum    = av + bv;
      ssum    = sa + sb;
      exp_cy  = (usum >= SPAN) ? 1 : 0;
      exp_res = usum % SPAN;
    end else begin
      usum    = av - bv;
      ssum    = sa - sb;
      exp_cy  = (av >= bv) ? 1 : 0;
      exp_res = (usum + SPAN) % SPAN;
    end
    exp_ov = (ssum > SMAX || ssum < SMIN) ? 1 : 0;
    // same-cycle settling of every output (R9)
    check(sv ? "R2" : "R1", int'(res), exp_res);
    check(sv ? "R6" : "R5", int'(cy), exp_cy);
    check(sv ? "R4" : "R3", int'(ov), exp_ov);
    if ((!sv && (sa < 0) != (sb < 0)) || (sv && (sa < 0) == (sb < 0)))
      check("R7", int'(ov), 0);
    if (sv && bv == 0) begin
      check("R8", int'(res), av);
      check("R8", int'(cy), 1);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; sub = 1'b0;
    @(negedge clk);
    check("R1", int'(res), 0);   // idle state with zero inputs
    check("R5", int'(cy), 0);
    check("R3", int'(ov), 0);

    // directed corners
    apply_and_check(5, 6, 1'b1);    // R2: 0101 - 0110 = 1111
    apply_and_check(8, 8, 1'b0);    // R3/R5: -8 + -8 wraps, carry and overflow together
    apply_and_check(7, 1, 1'b0);    // R3: +7 + 1
    apply_and_check(0, 8, 1'b1);    // R4: 0 - (-8)
    apply_and_check(8, 1, 1'b1);    // R4: -8 - 1
    apply_and_check(9, 0, 1'b1);    // R8
    apply_and_check(15, 15, 1'b1);  // R6: equal operands, no borrow

    // R9: back-to-back changes, each judged in its own cycle
    apply_and_check(3, 4, 1'b0);
    apply_and_check(3, 4, 1'b1);

    // exhaustive sweep over both modes
    for (int m = 0; m < 2; m++)
      for (int x = 0; x < SPAN; x++)
        for (int y = 0; y < SPAN; y++)
          apply_and_check(x, y, m[0]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule